// File: doc/BRIEF.md
# Parallel Four-Point Fast Fourier Transform

This block computes the discrete Fourier transform of four complex samples in a single pass of combinational logic. All four samples arrive at once on separate signed real and imaginary buses. All four frequency bins appear on the outputs after the logic settles, with no clock and no pipeline register on the path. The block suits a datapath that already holds a four-sample frame in registers and needs its spectrum within the same cycle.

The structure is a radix-2 decimation-in-time network with two stages. Each stage has two butterflies, and each butterfly forms the sum and the difference of two complex values. Four constant-coefficient complex multipliers sit between the stages. They all share one architecture and differ only in their twiddle parameters. The samples are reordered into bit-reversed order by wiring. The bins come out in natural order, from bin 0 to bin 3. The block has no state machine and no states, because nothing in it holds state.

Top module: `fft4_par`

## Requirements
- R1: Bin 0 equals the sum of all four samples, separately for the real and the imaginary part.
- R2: Bin 2 equals x0 − x1 + x2 − x3, separately for the real and the imaginary part.
- R3: Bin 1 equals (x0 − x2) − j(x1 − x3): its real part is (x0re − x2re) + (x1im − x3im) and its imaginary part is (x0im − x2im) − (x1re − x3re).
- R4: Bin 3 equals (x0 − x2) + j(x1 − x3): its real part is (x0re − x2re) − (x1im − x3im) and its imaginary part is (x0im − x2im) + (x1re − x3re).
- R5: The outputs follow a change of the inputs with no clock edge in between (zero latency).
- R6: Samples are 16-bit two's complement and bins are 18-bit two's complement. No input pattern overflows a bin, including the pattern where every sample is −32768.
- R7: Every butterfly produces a sum and a difference whose total equals twice its first input.
- R8: Twiddles are signed Q1.14 constants: unity is (16384, 0) and −j is (0, −16384). Each multiplier forms (ac − bd) + j(ad + bc) with four multiplies, then shifts arithmetically right by 14. For these constants the result is exact, so sample x1 = 1000 alone gives bin 1 = (0, −1000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| smp0_re | input | 16 | Sample 0, real part |
| smp0_im | input | 16 | Sample 0, imaginary part |
| smp1_re | input | 16 | Sample 1, real part |
| smp1_im | input | 16 | Sample 1, imaginary part |
| smp2_re | input | 16 | Sample 2, real part |
| smp2_im | input | 16 | Sample 2, imaginary part |
| smp3_re | input | 16 | Sample 3, real part |
| smp3_im | input | 16 | Sample 3, imaginary part |
| bin0_re | output | 18 | Bin 0, real part |
| bin0_im | output | 18 | Bin 0, imaginary part |
| bin1_re | output | 18 | Bin 1, real part |
| bin1_im | output | 18 | Bin 1, imaginary part |
| bin2_re | output | 18 | Bin 2, real part |
| bin2_im | output | 18 | Bin 2, imaginary part |
| bin3_re | output | 18 | Bin 3, real part |
| bin3_im | output | 18 | Bin 3, imaginary part |

## Verification
The block holds no state, so any fault shows up at the ports as soon as the inputs settle, on the same vector that exposes it. A wrong twiddle constant or a swapped real and imaginary path corrupts only bins 1 and 3, and it does so in a mirrored way. A sign error in a first-stage butterfly spoils a pair of bins at once. Impulses on each sample position separate these faults, while random frames and all-extreme frames expose truncation or overflow in the wider bins.

// File: rtl/fft4_pkg.sv
package fft4_pkg;

    localparam int DATA_W = 16;
    localparam int OUT_W  = 18;
    localparam int COEF_W = 16;
    localparam int FRAC_W = 14;
    localparam int POINTS = 4;

    // Real part of W4^e as a fixed-point constant with frac fraction bits
    function automatic int tw_re(input int e, input int frac);
        int one;
        one = 1 << frac;
        case (e % 4)
            0:       return one;
            2:       return -one;
            default: return 0;
        endcase
    endfunction

    // Imaginary part of W4^e = exp(-j*pi*e/2)
    function automatic int tw_im(input int e, input int frac);
        int one;
        one = 1 << frac;
        case (e % 4)
            1:       return -one;
            3:       return one;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fft4_bfly.sv
module fft4_bfly #(
    parameter int IW = 16
) (
    input  logic signed [IW-1:0] a_re,
    input  logic signed [IW-1:0] a_im,
    input  logic signed [IW-1:0] b_re,
    input  logic signed [IW-1:0] b_im,
    output logic signed [IW:0]   sum_re,
    output logic signed [IW:0]   sum_im,
    output logic signed [IW:0]   dif_re,
    output logic signed [IW:0]   dif_im
);
    localparam int XW = IW + 1;

    always_comb begin
        sum_re = XW'(a_re) + XW'(b_re);
        sum_im = XW'(a_im) + XW'(b_im);
        dif_re = XW'(a_re) - XW'(b_re);
        dif_im = XW'(a_im) - XW'(b_im);
    end

    // R7: the sum and the difference together give back twice the first input
    always_comb begin
        a_r7_bfly_re: assert ((XW+1)'(sum_re) + (XW+1)'(dif_re) == ((XW+1)'(a_re) <<< 1));
        a_r7_bfly_im: assert ((XW+1)'(sum_im) + (XW+1)'(dif_im) == ((XW+1)'(a_im) <<< 1));
    end

endmodule

// File: rtl/fft4_cmul.sv
module fft4_cmul #(
    parameter int IW   = 17,
    parameter int OW   = 18,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter int W_RE = 1 << 14,
    parameter int W_IM = 0
) (
    input  logic signed [IW-1:0] in_re,
    input  logic signed [IW-1:0] in_im,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im
);
    localparam int PW = IW + CW;
    localparam logic signed [CW-1:0] C_RE = CW'(W_RE);
    localparam logic signed [CW-1:0] C_IM = CW'(W_IM);

    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [PW:0]   acc_re, acc_im;
    logic signed [PW:0]   sh_re, sh_im;
    logic signed [PW:0]   back_re, back_im;

    always_comb begin
        p_rr   = PW'(in_re) * PW'(C_RE);
        p_ii   = PW'(in_im) * PW'(C_IM);
        p_ri   = PW'(in_re) * PW'(C_IM);
        p_ir   = PW'(in_im) * PW'(C_RE);
        acc_re = (PW+1)'(p_rr) - (PW+1)'(p_ii);
        acc_im = (PW+1)'(p_ri) + (PW+1)'(p_ir);
        sh_re  = acc_re >>> FRAC;
        sh_im  = acc_im >>> FRAC;
        out_re = sh_re[OW-1:0];
        out_im = sh_im[OW-1:0];
    end

    // R6: the scaled product fits the output width
    always_comb begin
        back_re = (PW+1)'(out_re);
        back_im = (PW+1)'(out_im);
        a_r6_mul_fits_re: assert (back_re == sh_re);
        a_r6_mul_fits_im: assert (back_im == sh_im);
    end

    // R8: exact constants give exact results
    generate
        if (W_RE == (1 << FRAC) && W_IM == 0) begin : g_unity
            always_comb begin
                a_r8_unity_re: assert (back_re == (PW+1)'(in_re));
                a_r8_unity_im: assert (back_im == (PW+1)'(in_im));
            end
        end else if (W_RE == 0 && W_IM == -(1 << FRAC)) begin : g_minus_j
            always_comb begin
                a_r8_minus_j_re: assert (back_re == (PW+1)'(in_im));
                a_r8_minus_j_im: assert (back_im == -(PW+1)'(in_re));
            end
        end
    endgenerate

endmodule

// File: rtl/fft4_par.sv
module fft4_par
    import fft4_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int OW   = OUT_W,
    parameter int CW   = COEF_W,
    parameter int FRAC = FRAC_W
) (
    input  logic signed [DW-1:0] smp0_re,
    input  logic signed [DW-1:0] smp0_im,
    input  logic signed [DW-1:0] smp1_re,
    input  logic signed [DW-1:0] smp1_im,
    input  logic signed [DW-1:0] smp2_re,
    input  logic signed [DW-1:0] smp2_im,
    input  logic signed [DW-1:0] smp3_re,
    input  logic signed [DW-1:0] smp3_im,
    output logic signed [OW-1:0] bin0_re,
    output logic signed [OW-1:0] bin0_im,
    output logic signed [OW-1:0] bin1_re,
    output logic signed [OW-1:0] bin1_im,
    output logic signed [OW-1:0] bin2_re,
    output logic signed [OW-1:0] bin2_im,
    output logic signed [OW-1:0] bin3_re,
    output logic signed [OW-1:0] bin3_im
);
    localparam int N    = POINTS;
    localparam int HALF = N / 2;
    localparam int SW   = DW + 1;   // after first stage
    localparam int MW   = SW + 1;   // after twiddle multiply
    localparam int FW   = MW + 1;   // after second stage

    logic signed [DW-1:0] x_re [N];
    logic signed [DW-1:0] x_im [N];
    logic signed [SW-1:0] s1_re [N];
    logic signed [SW-1:0] s1_im [N];
    logic signed [MW-1:0] m_re [N];
    logic signed [MW-1:0] m_im [N];
    logic signed [FW-1:0] f_re [N];
    logic signed [FW-1:0] f_im [N];
    logic signed [OW-1:0] y_re [N];
    logic signed [OW-1:0] y_im [N];

    assign x_re[0] = smp0_re;  assign x_im[0] = smp0_im;
    assign x_re[1] = smp1_re;  assign x_im[1] = smp1_im;
    assign x_re[2] = smp2_re;  assign x_im[2] = smp2_im;
    assign x_re[3] = smp3_re;  assign x_im[3] = smp3_im;

    genvar g;
    generate
        // First stage: even pair (x0,x2) and odd pair (x1,x3); the wiring does the bit reversal
        for (g = 0; g < HALF; g++) begin : g_stage1
            fft4_bfly #(.IW(DW)) i_bfly (
                .a_re  (x_re[g]),        .a_im  (x_im[g]),
                .b_re  (x_re[g+HALF]),   .b_im  (x_im[g+HALF]),
                .sum_re(s1_re[2*g]),     .sum_im(s1_im[2*g]),
                .dif_re(s1_re[2*g+1]),   .dif_im(s1_im[2*g+1])
            );
        end

        // Twiddles: W^0 everywhere except on the odd-pair difference, which takes W^1
        for (g = 0; g < N; g++) begin : g_twiddle
            localparam int EXP = (g == N - 1) ? 1 : 0;
            fft4_cmul #(
                .IW(SW), .OW(MW), .CW(CW), .FRAC(FRAC),
                .W_RE(tw_re(EXP, FRAC)), .W_IM(tw_im(EXP, FRAC))
            ) i_cmul (
                .in_re (s1_re[g]), .in_im (s1_im[g]),
                .out_re(m_re[g]),  .out_im(m_im[g])
            );
        end

        // Second stage: bins k and k+2 come from the k-th even and odd results
        for (g = 0; g < HALF; g++) begin : g_stage2
            fft4_bfly #(.IW(MW)) i_bfly (
                .a_re  (m_re[g]),        .a_im  (m_im[g]),
                .b_re  (m_re[g+HALF]),   .b_im  (m_im[g+HALF]),
                .sum_re(f_re[g]),        .sum_im(f_im[g]),
                .dif_re(f_re[g+HALF]),   .dif_im(f_im[g+HALF])
            );
        end

        for (g = 0; g < N; g++) begin : g_trim
            assign y_re[g] = f_re[g][OW-1:0];
            assign y_im[g] = f_im[g][OW-1:0];
            // R6: dropping the top bit never changes a bin's value
            always_comb begin
                a_r6_no_overflow_re: assert (FW'(y_re[g]) == f_re[g]);
                a_r6_no_overflow_im: assert (FW'(y_im[g]) == f_im[g]);
            end
        end
    endgenerate

    assign bin0_re = y_re[0];  assign bin0_im = y_im[0];
    assign bin1_re = y_re[1];  assign bin1_im = y_im[1];
    assign bin2_re = y_re[2];  assign bin2_im = y_im[2];
    assign bin3_re = y_re[3];  assign bin3_im = y_im[3];

    // R1: the DC bin relates the input ports directly to the output ports
    always_comb begin
        a_r1_dc_re: assert (int'(bin0_re) == int'(smp0_re) + int'(smp1_re) + int'(smp2_re) + int'(smp3_re));
        a_r1_dc_im: assert (int'(bin0_im) == int'(smp0_im) + int'(smp1_im) + int'(smp2_im) + int'(smp3_im));
    end

    // R2: the alternating bin
    always_comb begin
        a_r2_alt_re: assert (int'(bin2_re) == int'(smp0_re) - int'(smp1_re) + int'(smp2_re) - int'(smp3_re));
        a_r2_alt_im: assert (int'(bin2_im) == int'(smp0_im) - int'(smp1_im) + int'(smp2_im) - int'(smp3_im));
    end

endmodule

// File: tb/test_fft4_par.sv
module test_fft4_par;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NRAND      = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic signed [15:0] xr [4];
    logic signed [15:0] xi [4];
    logic signed [17:0] yr [4];
    logic signed [17:0] yi [4];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fft4_par i_fft4_par (
        .smp0_re(xr[0]), .smp0_im(xi[0]),
        .smp1_re(xr[1]), .smp1_im(xi[1]),
        .smp2_re(xr[2]), .smp2_im(xi[2]),
        .smp3_re(xr[3]), .smp3_im(xi[3]),
        .bin0_re(yr[0]), .bin0_im(yi[0]),
        .bin1_re(yr[1]), .bin1_im(yi[1]),
        .bin2_re(yr[2]), .bin2_im(yi[2]),
        .bin3_re(yr[3]), .bin3_im(yi[3])
    );

    // Behavioural DFT with twiddles W^m = exp(-j*pi*m/2)
    function automatic int w_re(int m);
        case (m % 4) 0: return 1; 2: return -1; default: return 0; endcase
    endfunction
    function automatic int w_im(int m);
        case (m % 4) 1: return -1; 3: return 1; default: return 0; endcase
    endfunction
    function automatic int dft_re(int k);
        int acc = 0;
        for (int n = 0; n < 4; n++)
            acc += int'(xr[n]) * w_re(k*n) - int'(xi[n]) * w_im(k*n);
        return acc;
    endfunction
    function automatic int dft_im(int k);
        int acc = 0;
        for (int n = 0; n < 4; n++)
            acc += int'(xr[n]) * w_im(k*n) + int'(xi[n]) * w_re(k*n);
        return acc;
    endfunction

    task automatic check(string req, int act, int exp, int tol);
        checks++;
        if (act - exp > tol || exp - act > tol) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string bin_req(int k);
        case (k) 0: return "R1 bin0"; 1: return "R3 bin1"; 2: return "R2 bin2"; default: return "R4 bin3"; endcase
    endfunction

    task automatic check_all(string tag);
        for (int k = 0; k < 4; k++) begin
            check({bin_req(k), " re ", tag}, int'(yr[k]), dft_re(k), 1);
            check({bin_req(k), " im ", tag}, int'(yi[k]), dft_im(k), 1);
        end
    endtask

    task automatic apply(int r0, int i0, int r1, int i1, int r2, int i2, int r3, int i3);
        @(posedge clk);
        xr[0] = 16'(r0); xi[0] = 16'(i0); xr[1] = 16'(r1); xi[1] = 16'(i1);
        xr[2] = 16'(r2); xi[2] = 16'(i2); xr[3] = 16'(r3); xi[3] = 16'(i3);
        @(negedge clk);
    endtask

    initial begin
        int seed;
        for (int n = 0; n < 4; n++) begin xr[n] = '0; xi[n] = '0; end
        seed = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: idle zero inputs give zero bins (R1..R4)
        check_all("zero");

        // Impulses on each position
        for (int p = 0; p < 4; p++) begin
            apply(p==0 ? 1 : 0, 0, p==1 ? 1 : 0, 0, p==2 ? 1 : 0, 0, p==3 ? 1 : 0, 0);
            check_all("impulse");
        end

        // R8: lone x1 through the -j twiddle, exact
        apply(0, 0, 1000, 0, 0, 0, 0, 0);
        check("R8 bin1 re exact", int'(yr[1]), 0, 0);
        check("R8 bin1 im exact", int'(yi[1]), -1000, 0);
        check("R8 bin3 im exact", int'(yi[3]), 1000, 0);

        // R6: extremes
        apply(-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768);
        check("R6 R1 bin0 re min", int'(yr[0]), -131072, 0);
        check("R6 R1 bin0 im min", int'(yi[0]), -131072, 0);
        apply(32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767);
        check("R6 R1 bin0 re max", int'(yr[0]), 131068, 0);
        apply(32767, -32768, -32768, 32767, 32767, -32768, -32768, 32767);
        check_all("R6 alternating extremes");
        apply(32767, 0, 0, 32767, -32768, 0, 0, -32768);
        check_all("R6 bin1 peak");

        // R5: outputs follow the inputs with no clock edge in between
        @(posedge clk);
        #1;
        xr[0] = 16'sd500; xi[0] = 16'sd0; xr[1] = 16'sd0; xi[1] = 16'sd0;
        xr[2] = 16'sd0;   xi[2] = 16'sd0; xr[3] = 16'sd0; xi[3] = 16'sd0;
        #1;
        check("R5 bin2 re same time", int'(yr[2]), 500, 0);
        xr[2] = 16'sd200;
        #1;
        check("R5 bin2 re second change", int'(yr[2]), 700, 0);
        check("R5 bin1 re second change", int'(yr[1]), 300, 0);

        // Random frames
        for (int v = 0; v < NRAND; v++) begin
            apply($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
            check_all("random");
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, WATCHDOG);
        end
        #1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule